// File: doc/BRIEF.md
# Multi-Channel DMA Request Arbiter

This block chooses which of seven DMA channels may use the transfer engine next. Each channel presents a request line, an enable bit and a two-bit priority that software sets. Of the channels that are enabled and requesting, the block picks the one with the highest priority. When two or more candidates share that priority, the lowest channel index wins. The decision is registered. The block then presents a one-hot grant together with a valid strobe.

Once it has issued a grant, the arbiter holds it unchanged while the engine carries out a single data transfer for that channel. The engine pulses a done input when the transfer ends. At the edge that samples done, the grant is withdrawn. A fresh decision is made at the next edge, which gives the finished channel one cycle to drop its request. The block does not generate addresses, access the bus or raise interrupts.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `grant_o` is all zeros and `grant_valid_o` is low until a decision is made.
- R2: Only a channel whose `req_i` bit and `en_i` bit are both high can be granted. A requesting channel that is disabled is never granted.
- R3: Channel i takes its priority from `prio_i[2i+1:2i]`, where 3 is very high, 2 is high, 1 is medium and 0 is low. Among eligible channels the highest code wins.
- R4: When several eligible channels share the highest code, the one with the lowest index wins.
- R5: The decision is registered. Inputs sampled at a clock edge while no grant is active appear on `grant_o` right after that edge.
- R6: `grant_o` has at most one bit set, and `grant_valid_o` is high exactly when a bit is set.
- R7: While a grant is active and `xfer_done_i` is low, `grant_o` does not change, even if requests, enables or priorities change.
- R8: When `xfer_done_i` is sampled high during an active grant, the grant clears after that edge. Arbitration resumes at the following edge.
- R9: With no eligible channel and no active grant, `grant_o` stays zero and `grant_valid_o` stays low.
- R10: `xfer_done_i` has no effect while no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 7 | Per-channel transfer request |
| en_i | input | 7 | Per-channel enable |
| prio_i | input | 14 | Packed priorities, two bits per channel |
| xfer_done_i | input | 1 | Engine pulse: the current single transfer has ended |
| grant_o | output | 7 | One-hot grant |
| grant_valid_o | output | 1 | A grant is active |

## Verification
The hardest situation to reach is a higher-priority channel that arrives, or has its priority raised, while a grant is already being held. The expected result is that nothing moves until done, and that the newcomer wins the decision made after the gap cycle. Directed sequences build this case on purpose, including done pulses that arrive while the arbiter is idle. A long random phase then changes the requests, enables and priorities on every cycle and raises done with moderate probability. The bench checks every cycle against a cycle model derived from the requirements, so holds, releases and ties also collide with mid-transfer changes.

// File: rtl/dma_arb_pkg.sv
// Package: widths, priority codes and arbiter state shared by the arbiter.
// Assumes priority fields are two bits, with larger codes more urgent.
package dma_arb_pkg;
    localparam int PRIO_W = 2;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam prio_t PRIO_LOW   = 2'd0;
    localparam prio_t PRIO_MED   = 2'd1;
    localparam prio_t PRIO_HIGH  = 2'd2;
    localparam prio_t PRIO_VHIGH = 2'd3;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dma_arb_eligible.sv
// Eligibility stage: qualifies each request with its enable and unpacks the
// flat priority bus into one field per channel.
// Assumes channel i owns prio_flat_i[PRIO_W*i +: PRIO_W].
module dma_arb_eligible
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic [NUM_CH-1:0]        req_i,
    input  logic [NUM_CH-1:0]        en_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat_i,
    output logic [NUM_CH-1:0]        elig_o,
    output prio_t                    prio_o [NUM_CH]
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        // Mask a request unless its channel is enabled.
        assign elig_o[ch] = req_i[ch] & en_i[ch];
        // Slice out this channel's priority field.
        assign prio_o[ch] = prio_flat_i[PRIO_W*ch +: PRIO_W];
    end
endmodule

// File: rtl/dma_arb_pick.sv
// Selection stage: combinational two-tier choice. The highest priority code
// wins, and the lowest index breaks ties. The output is one-hot or zero.
// Assumes prio_i holds valid codes for every channel, eligible or not.
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic [NUM_CH-1:0] elig_i,
    input  prio_t             prio_i [NUM_CH],
    output logic [NUM_CH-1:0] win_o,
    output logic              win_any_o
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [IDX_W-1:0] best_idx;
    prio_t            best_prio;
    logic             found;

    // Scan from the top index down; '>=' lets lower indices take ties.
    always_comb begin
        best_idx  = '0;
        best_prio = PRIO_LOW;
        found     = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig_i[i] && (!found || prio_i[i] >= best_prio)) begin
                best_idx  = IDX_W'(i);
                best_prio = prio_i[i];
                found     = 1'b1;
            end
        end
    end

    // Decode the winning index into a one-hot vector.
    always_comb begin
        win_o = '0;
        if (found) begin
            win_o[best_idx] = 1'b1;
        end
    end

    assign win_any_o = found;
endmodule

// File: rtl/dma_arb_hold.sv
// Grant register: loads a winner while idle and holds it until the engine
// signals done. It then returns to idle for one cycle before re-deciding.
// Assumes done is a single-cycle pulse from the transfer engine.
module dma_arb_hold
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] win_i,
    input  logic              win_any_i,
    input  logic              done_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic              valid_o
);
    arb_state_e       state_q;
    logic [NUM_CH-1:0] grant_q;

    // Capture a decision when idle; release it on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (win_any_i) begin
                        grant_q <= win_i;
                        state_q <= ARB_OWNED;
                    end
                end
                ARB_OWNED: begin
                    if (done_i) begin
                        grant_q <= '0;
                        state_q <= ARB_IDLE;
                    end
                end
                default: begin
                    grant_q <= '0;
                    state_q <= ARB_IDLE;
                end
            endcase
        end
    end

    assign grant_o = grant_q;
    assign valid_o = (state_q == ARB_OWNED);
endmodule

// File: rtl/dma_req_arbiter.sv
// Top: seven-channel DMA request arbiter. It qualifies the requests, picks by
// software priority and then by index, and holds the registered grant for
// one transfer.
// Assumes synchronous active-low reset and a done pulse per transfer.
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req_i,
    input  logic [NUM_CH-1:0]        en_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    input  logic                     xfer_done_i,
    output logic [NUM_CH-1:0]        grant_o,
    output logic                     grant_valid_o
);
    logic [NUM_CH-1:0] elig;
    prio_t             prio_arr [NUM_CH];
    logic [NUM_CH-1:0] win;
    logic              win_any;

    dma_arb_eligible #(.NUM_CH(NUM_CH)) u_elig (
        .req_i       (req_i),
        .en_i        (en_i),
        .prio_flat_i (prio_i),
        .elig_o      (elig),
        .prio_o      (prio_arr)
    );

    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig_i    (elig),
        .prio_i    (prio_arr),
        .win_o     (win),
        .win_any_o (win_any)
    );

    dma_arb_hold #(.NUM_CH(NUM_CH)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_i     (win),
        .win_any_i (win_any),
        .done_i    (xfer_done_i),
        .grant_o   (grant_o),
        .valid_o   (grant_valid_o)
    );
endmodule

// File: rtl/dma_arb_chk.sv
// Checker: temporal properties of the arbiter's ports, bound to the top.
// Assumes it observes the same clock and reset as the top.
module dma_arb_chk
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        req_i,
    input logic [NUM_CH-1:0]        en_i,
    input logic [NUM_CH*PRIO_W-1:0] prio_i,
    input logic                     xfer_done_i,
    input logic [NUM_CH-1:0]        grant_o,
    input logic                     grant_valid_o
);
    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R6
    valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o == (|grant_o));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !xfer_done_i) |=> $stable(grant_o));

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && xfer_done_i) |=> !grant_valid_o);

    // R2
    grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid_o && |(req_i & en_i)) |=> |(grant_o & $past(req_i & en_i)));

    // R5
    decide_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid_o && |(req_i & en_i)) |=> grant_valid_o);

    // R9
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid_o && !(|(req_i & en_i))) |=> !grant_valid_o);

    // Priority bus is observed for completeness of the bound port list.
    logic unused_prio;
    assign unused_prio = ^prio_i;
endmodule

bind dma_req_arbiter dma_arb_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .en_i          (en_i),
    .prio_i        (prio_i),
    .xfer_done_i   (xfer_done_i),
    .grant_o       (grant_o),
    .grant_valid_o (grant_valid_o)
);

// File: tb/dma_req_arbiter_tb_top.sv
// Bench: directed corner cases plus seeded random stimulus. Every cycle is
// checked against a cycle model built from the requirements.
module dma_req_arbiter_tb_top;
    localparam int N  = 7;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req, en;
    logic [N*PW-1:0] prio;
    logic          done;
    logic [N-1:0]  grant;
    logic          gvalid;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    logic [N-1:0] exp_grant;
    logic         exp_valid;

    always #5 clk = ~clk;

    dma_req_arbiter #(.NUM_CH(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .prio_i(prio),
        .xfer_done_i(done), .grant_o(grant), .grant_valid_o(gvalid)
    );

    // Spec-level choice: scan levels from very high down, lowest index first.
    function automatic logic [N-1:0] pick(input logic [N-1:0] r, input logic [N-1:0] e,
                                          input logic [N*PW-1:0] p);
        for (int lvl = 3; lvl >= 0; lvl--)
            for (int c = 0; c < N; c++)
                if (r[c] && e[c] && int'(p[PW*c +: PW]) == lvl)
                    return N'(1) << c;
        return '0;
    endfunction

    // Cycle model of the grant register.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_grant <= '0;
            exp_valid <= 1'b0;
        end else if (exp_valid) begin
            if (done) begin
                exp_grant <= '0;
                exp_valid <= 1'b0;
            end
        end else begin
            exp_grant <= pick(req, en, prio);
            exp_valid <= |pick(req, en, prio);
        end
    end

    task automatic check_model();
        checks++;
        if (grant !== exp_grant || gvalid !== exp_valid) begin
            errors++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     tag, grant, gvalid, exp_grant, exp_valid);
        end
    endtask

    task automatic check_lit(input string t, input logic [N-1:0] g, input logic v);
        checks++;
        if (grant !== g || gvalid !== v) begin
            errors++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     t, grant, gvalid, g, v);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check_model();
    endtask

    function automatic logic [N*PW-1:0] setp(input logic [N*PW-1:0] p, input int c,
                                             input logic [PW-1:0] v);
        logic [N*PW-1:0] q = p;
        q[PW*c +: PW] = v;
        return q;
    endfunction

    // Finish the current grant and wait for idle.
    task automatic release_grant();
        req = '0; done = 1'b1;
        step();
        done = 1'b0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req = '0; en = '0; prio = '0; done = 1'b0;
        req = 7'b1111111; en = 7'b1111111;
        // R1: reset holds outputs low even with requests pending.
        repeat (3) @(negedge clk);
        tag = "R1";
        check_lit("R1", 7'b0, 1'b0);
        req = '0; en = '0;
        rst_n = 1'b1;
        step();
        check_lit("R1", 7'b0, 1'b0);

        // R9: nothing eligible (requests without enable, enables without requests).
        tag = "R9";
        req = 7'b0101010; en = 7'b1010101;
        step(); step();
        check_lit("R9", 7'b0, 1'b0);

        // R10: done while idle does nothing.
        tag = "R10";
        done = 1'b1;
        step();
        check_lit("R10", 7'b0, 1'b0);
        done = 1'b0;

        // R2: disabled channel 1 at very high is masked; enabled channel 4 wins.
        tag = "R2";
        en = 7'b1111101; req = 7'b0010010;
        prio = setp('0, 1, 2'd3);
        prio = setp(prio, 4, 2'd0);
        step();
        check_lit("R2", 7'b0010000, 1'b1);
        release_grant();

        // R3: channel 6 at very high beats channel 0 at medium.
        tag = "R3";
        en = '1; req = 7'b1000001;
        prio = setp('0, 0, 2'd1);
        prio = setp(prio, 6, 2'd3);
        step();
        check_lit("R3", 7'b1000000, 1'b1);
        release_grant();

        // R4: channels 2 and 5 tie at high; channel 3 is lower; channel 2 wins.
        tag = "R4";
        req = 7'b0101100;
        prio = setp('0, 2, 2'd2);
        prio = setp(prio, 5, 2'd2);
        prio = setp(prio, 3, 2'd1);
        step();
        check_lit("R4", 7'b0000100, 1'b1);

        // R7: raise channel 0 to very high mid-transfer; the grant must not move.
        tag = "R7";
        req = 7'b0101101;
        prio = setp(prio, 0, 2'd3);
        step(); step(); step();
        check_lit("R7", 7'b0000100, 1'b1);

        // R8: done clears the grant, and the next decision picks channel 0.
        tag = "R8";
        done = 1'b1;
        step();
        check_lit("R8", 7'b0, 1'b0);
        done = 1'b0;
        step();
        check_lit("R8", 7'b0000001, 1'b1);
        release_grant();

        // R5: the grant appears on the cycle after the request is sampled.
        tag = "R5";
        req = 7'b0001000; prio = '0;
        check_lit("R5", 7'b0, 1'b0);
        step();
        check_lit("R5", 7'b0001000, 1'b1);
        release_grant();

        // R3, R4, R6, R7, R8: random traffic checked each cycle.
        tag = "R3 R4 R6";
        for (int k = 0; k < 4000; k++) begin
            req  = N'($urandom);
            en   = N'($urandom) | N'($urandom);
            prio = (N*PW)'($urandom);
            done = ($urandom % 3) == 0;
            step();
            checks++;
            if (!$onehot0(grant)) begin
                errors++;
                $display("FAIL R6: grant=%b expected at most one bit set", grant);
            end
        end

        done = 1'b0; req = '0;
        step(); step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule